// File: doc/BRIEF.md
# Superscalar Register Rename Unit

This block translates the architectural register numbers of a decoded instruction group into physical register numbers. The default group is two instructions wide, with 32 architectural and 64 physical registers. A mapping table holds the newest physical register for each architectural register. A circular free list hands out unused physical registers in first-in first-out order. For every instruction that writes a register, the block also returns the mapping being replaced, so that the surrounding pipeline can keep it in its instruction record. The block reads and moves no register data.

The pipeline returns instruction records through two ports. A commit record gives the replaced mapping back to the free list, because the register that held the older value is now dead. A rollback record restores the replaced mapping into the table and gives the squashed instruction's new register back to the free list. Rollback records are presented youngest first, one per cycle. A two-state control machine governs when a group may be renamed:

- `REN_RUN` is the normal state.
- The transition `RUN->UNDO` is taken when `rb_active` is high at a clock edge.
- `REN_UNDO` holds while `rb_active` stays high.
- The transition `UNDO->RUN` is taken at the first edge where `rb_active` is low.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers 32..63 and hands them out in ascending order.
- R2: A group is renamed only when at least one slot is valid. A valid slot with `ren_dst_we`=1 and a nonzero destination then takes the next free register, in slot order (slot 0 first), and `ren_alloc` for that slot is 1.
- R3: Each source maps to the newest mapping of its register. If an older slot in the same group writes that register, the source takes that slot's new register instead of the table value.
- R4: `ren_old_pdst` gives the mapping that the destination replaces, including a new register from an older slot in the same group. When two slots write the same register, the younger slot's register stays in the table.
- R5: Architectural register 0 always reads physical 0. A destination of 0 takes no register (`ren_alloc`=0, `ren_pdst`=0) and leaves the table unchanged.
- R6: If the free list holds fewer registers than the group needs, `ren_ok`=0 and the whole group is refused. The table and the free list stay unchanged.
- R7: A commit record with `cm_has_dst`=1 appends `cm_old_pdst` to the tail of the free list. That register is reused after every register already ahead of it.
- R8: A rollback record with `rb_has_dst`=1 writes `rb_old_pdst` into the table entry `rb_adst` and appends `rb_pdst` to the tail of the free list.
- R9: Rename is refused (`ren_ok`=0) in four cases: while `rb_active` is 1, while `rb_valid` is 1, in the `REN_UNDO` state, and in the first cycle after `rb_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | GROUP | Slot valid bits |
| ren_dst_we | input | GROUP | Slot writes a destination |
| ren_adst | input | GROUP*AW | Architectural destinations |
| ren_asrc1 | input | GROUP*AW | Architectural first sources |
| ren_asrc2 | input | GROUP*AW | Architectural second sources |
| ren_ok | output | 1 | Group accepted this cycle |
| ren_alloc | output | GROUP | Slot received a new register |
| ren_pdst | output | GROUP*PW | New physical destinations |
| ren_psrc1 | output | GROUP*PW | Physical first sources |
| ren_psrc2 | output | GROUP*PW | Physical second sources |
| ren_old_pdst | output | GROUP*PW | Replaced mapping per slot |
| cm_valid | input | 1 | Commit record present |
| cm_has_dst | input | 1 | Committed instruction had a destination |
| cm_old_pdst | input | PW | Replaced mapping to free |
| rb_active | input | 1 | Rollback in progress |
| rb_valid | input | 1 | Rollback record present |
| rb_has_dst | input | 1 | Squashed instruction had a destination |
| rb_adst | input | AW | Squashed destination register |
| rb_pdst | input | PW | Squashed new register, to free |
| rb_old_pdst | input | PW | Mapping to restore |

## Verification
The rename results (`ren_ok`, `ren_alloc` and the physical numbers) are combinational and valid in the same cycle as the request. The table and free-list effects of a rename, commit or rollback show from the next cycle. `REN_UNDO` refuses renames for one extra cycle after `rb_active` falls. The driver applies each request at the falling edge and queues the expected item, and the scoreboard compares it 1 ns later, before the rising edge that commits it. Hidden state is read back only through later rename groups whose slots write no destination.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic {
        REN_RUN  = 1'b0,
        REN_UNDO = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NPHYS = 64,
    parameter int NARCH = 32,
    parameter int GROUP = 2,
    parameter int NPUSH = 2,
    localparam int PW    = $clog2(NPHYS),
    localparam int IW    = $clog2(NPHYS),
    localparam int CW    = IW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW-1:0]              pop_n,
    input  logic [NPUSH-1:0]           push_vld,
    input  logic [NPUSH-1:0][PW-1:0]   push_reg,
    output logic [GROUP-1:0][PW-1:0]   peek,
    output logic [CW-1:0]              count
);
    localparam int DEPTH = NPHYS;
    localparam int INIT  = NPHYS - NARCH;

    logic [PW-1:0] mem_q [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [NPUSH-1:0][IW-1:0] widx;
    logic [CW-1:0] push_n;

    for (genvar g = 0; g < GROUP; g++) begin : g_peek
        assign peek[g] = mem_q[head_q + IW'(g)];
    end

    always_comb begin
        int off;
        off = 0;
        for (int p = 0; p < NPUSH; p++) begin
            widx[p] = tail_q + IW'(off);
            if (push_vld[p]) off++;
        end
        push_n = CW'(off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i < INIT) ? PW'(NARCH + i) : '0;
            head_q <= '0;
            tail_q <= IW'(INIT);
            cnt_q  <= CW'(INIT);
        end else begin
            for (int p = 0; p < NPUSH; p++)
                if (push_vld[p]) mem_q[widx[p]] <= push_reg[p];
            head_q <= head_q + IW'(pop_n);
            tail_q <= tail_q + IW'(push_n);
            cnt_q  <= cnt_q + push_n - pop_n;
        end
    end

    assign count = cnt_q;

    // R6
    fl_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= cnt_q);

    // R7
    fl_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + int'(push_n) - int'(pop_n)) <= DEPTH);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int GROUP = 2,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS),
    localparam int NRD  = 3 * GROUP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][AW-1:0]    rd_idx,
    output logic [NRD-1:0][PW-1:0]    rd_val,
    input  logic [GROUP-1:0]          wr_en,
    input  logic [GROUP-1:0][AW-1:0]  wr_idx,
    input  logic [GROUP-1:0][PW-1:0]  wr_val,
    input  logic                      rb_en,
    input  logic [AW-1:0]             rb_idx,
    input  logic [PW-1:0]             rb_val
);
    logic [PW-1:0] map_q [NARCH];

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_val[k] = map_q[rd_idx[k]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
        end else begin
            // later slots override earlier ones
            for (int i = 0; i < GROUP; i++)
                if (wr_en[i] && wr_idx[i] != '0) map_q[wr_idx[i]] <= wr_val[i];
            if (rb_en && rb_idx != '0) map_q[rb_idx] <= rb_val;
        end
    end

    // R8
    rb_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_en && rb_idx != '0) |=> map_q[$past(rb_idx)] == $past(rb_val));
endmodule

// File: rtl/rn_group_dep.sv
module rn_group_dep #(
    parameter int GROUP = 2,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic [GROUP-1:0][AW-1:0] asrc1,
    input  logic [GROUP-1:0][AW-1:0] asrc2,
    input  logic [GROUP-1:0][AW-1:0] adst,
    input  logic [GROUP-1:0][PW-1:0] tbl_s1,
    input  logic [GROUP-1:0][PW-1:0] tbl_s2,
    input  logic [GROUP-1:0][PW-1:0] tbl_d,
    input  logic [GROUP-1:0]         alloc,
    input  logic [GROUP-1:0][PW-1:0] new_p,
    output logic [GROUP-1:0][PW-1:0] psrc1,
    output logic [GROUP-1:0][PW-1:0] psrc2,
    output logic [GROUP-1:0][PW-1:0] pold
);
    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            psrc1[i] = tbl_s1[i];
            psrc2[i] = tbl_s2[i];
            pold[i]  = tbl_d[i];
            // ascending scan: the youngest older writer wins
            for (int j = 0; j < i; j++) begin
                if (alloc[j] && adst[j] == asrc1[i]) psrc1[i] = new_p[j];
                if (alloc[j] && adst[j] == asrc2[i]) psrc2[i] = new_p[j];
                if (alloc[j] && adst[j] == adst[i])  pold[i]  = new_p[j];
            end
        end
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int GROUP = 2,
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(NPHYS) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GROUP-1:0]          ren_valid,
    input  logic [GROUP-1:0]          ren_dst_we,
    input  logic [GROUP-1:0][AW-1:0]  ren_adst,
    input  logic [GROUP-1:0][AW-1:0]  ren_asrc1,
    input  logic [GROUP-1:0][AW-1:0]  ren_asrc2,
    output logic                      ren_ok,
    output logic [GROUP-1:0]          ren_alloc,
    output logic [GROUP-1:0][PW-1:0]  ren_pdst,
    output logic [GROUP-1:0][PW-1:0]  ren_psrc1,
    output logic [GROUP-1:0][PW-1:0]  ren_psrc2,
    output logic [GROUP-1:0][PW-1:0]  ren_old_pdst,
    input  logic                      cm_valid,
    input  logic                      cm_has_dst,
    input  logic [PW-1:0]             cm_old_pdst,
    input  logic                      rb_active,
    input  logic                      rb_valid,
    input  logic                      rb_has_dst,
    input  logic [AW-1:0]             rb_adst,
    input  logic [PW-1:0]             rb_pdst,
    input  logic [PW-1:0]             rb_old_pdst
);
    import rn_pkg::*;

    localparam int NRD = 3 * GROUP;

    rn_state_e state_q, state_d;

    logic [GROUP-1:0]          want, alloc;
    logic [CW-1:0]             need, fl_count, pop_n;
    logic [GROUP-1:0][PW-1:0]  fl_peek, new_p;
    logic [NRD-1:0][AW-1:0]    rd_idx;
    logic [NRD-1:0][PW-1:0]    rd_val;
    logic [GROUP-1:0][PW-1:0]  tbl_s1, tbl_s2, tbl_d;
    logic [1:0]                push_vld;
    logic [1:0][PW-1:0]        push_reg;

    // slot demand and free-list slice per slot
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < GROUP; i++) begin
            want[i]  = ren_valid[i] && ren_dst_we[i] && (ren_adst[i] != '0);
            new_p[i] = fl_peek[cnt];
            if (want[i]) cnt++;
        end
        need = CW'(cnt);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REN_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REN_RUN:  if (rb_active)  state_d = REN_UNDO;
            REN_UNDO: if (!rb_active) state_d = REN_RUN;
            default:  state_d = REN_RUN;
        endcase
    end

    // outputs of the control machine
    always_comb begin
        ren_ok = 1'b0;
        unique case (state_q)
            REN_RUN:  ren_ok = !rb_active && !rb_valid && (|ren_valid) && (fl_count >= need);
            REN_UNDO: ren_ok = 1'b0;
            default:  ren_ok = 1'b0;
        endcase
    end

    assign alloc     = want & {GROUP{ren_ok}};
    assign ren_alloc = alloc;
    assign pop_n     = ren_ok ? need : '0;

    for (genvar g = 0; g < GROUP; g++) begin : g_slot
        assign rd_idx[3*g]   = ren_asrc1[g];
        assign rd_idx[3*g+1] = ren_asrc2[g];
        assign rd_idx[3*g+2] = ren_adst[g];
        assign tbl_s1[g]     = rd_val[3*g];
        assign tbl_s2[g]     = rd_val[3*g+1];
        assign tbl_d[g]      = rd_val[3*g+2];
        assign ren_pdst[g]   = alloc[g] ? new_p[g] : '0;

        // R5
        zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_asrc1[g] == '0) |-> (ren_psrc1[g] == '0));

        // R2
        nonzero_pdst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ren_alloc[g] |-> (ren_pdst[g] != '0));
    end

    assign push_vld[0] = cm_valid && cm_has_dst;
    assign push_reg[0] = cm_old_pdst;
    assign push_vld[1] = rb_valid && rb_has_dst;
    assign push_reg[1] = rb_pdst;

    rn_free_list #(.NPHYS(NPHYS), .NARCH(NARCH), .GROUP(GROUP), .NPUSH(2)) u_free (
        .clk(clk), .rst_n(rst_n), .pop_n(pop_n),
        .push_vld(push_vld), .push_reg(push_reg),
        .peek(fl_peek), .count(fl_count)
    );

    rn_map_table #(.NARCH(NARCH), .NPHYS(NPHYS), .GROUP(GROUP)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_val(rd_val),
        .wr_en(alloc), .wr_idx(ren_adst), .wr_val(new_p),
        .rb_en(rb_valid && rb_has_dst), .rb_idx(rb_adst), .rb_val(rb_old_pdst)
    );

    rn_group_dep #(.GROUP(GROUP), .AW(AW), .PW(PW)) u_dep (
        .asrc1(ren_asrc1), .asrc2(ren_asrc2), .adst(ren_adst),
        .tbl_s1(tbl_s1), .tbl_s2(tbl_s2), .tbl_d(tbl_d),
        .alloc(alloc), .new_p(new_p),
        .psrc1(ren_psrc1), .psrc2(ren_psrc2), .pold(ren_old_pdst)
    );

    // R9
    rollback_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_active || rb_valid) |-> !ren_ok);

    // R6
    short_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0) |-> (ren_alloc == '0));
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
    localparam int G = 2, NA = 32, NP = 64, AW = 5, PW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [G-1:0] ren_valid, ren_dst_we, ren_ok_dummy;
    logic [G-1:0][AW-1:0] ren_adst, ren_asrc1, ren_asrc2;
    logic ren_ok;
    logic [G-1:0] ren_alloc;
    logic [G-1:0][PW-1:0] ren_pdst, ren_psrc1, ren_psrc2, ren_old_pdst;
    logic cm_valid, cm_has_dst, rb_active, rb_valid, rb_has_dst;
    logic [PW-1:0] cm_old_pdst, rb_pdst, rb_old_pdst;
    logic [AW-1:0] rb_adst;

    rename_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_dst_we(ren_dst_we),
        .ren_adst(ren_adst), .ren_asrc1(ren_asrc1), .ren_asrc2(ren_asrc2),
        .ren_ok(ren_ok), .ren_alloc(ren_alloc), .ren_pdst(ren_pdst),
        .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2), .ren_old_pdst(ren_old_pdst),
        .cm_valid(cm_valid), .cm_has_dst(cm_has_dst), .cm_old_pdst(cm_old_pdst),
        .rb_active(rb_active), .rb_valid(rb_valid), .rb_has_dst(rb_has_dst),
        .rb_adst(rb_adst), .rb_pdst(rb_pdst), .rb_old_pdst(rb_old_pdst)
    );

    typedef struct { int ad; int pd; int od; bit has; } rec_t;
    typedef struct {
        bit ok; bit v[2]; bit al[2];
        int pd[2]; int s1[2]; int s2[2]; int od[2];
        string tag;
    } exp_t;

    int map_m [NA];
    int fl_m [$];
    rec_t recs [$];
    exp_t sbq [$];
    bit undo_m = 1'b0;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    event ev_chk;

    always @(posedge clk) undo_m <= rb_active;

    task automatic check_int(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ren_valid = '0; ren_dst_we = '0; ren_adst = '0; ren_asrc1 = '0; ren_asrc2 = '0;
        cm_valid = 0; cm_has_dst = 0; cm_old_pdst = '0;
        rb_active = 0; rb_valid = 0; rb_has_dst = 0; rb_adst = '0; rb_pdst = '0; rb_old_pdst = '0;
    endtask

    // driver: one rename group, expected values from the reference model
    task automatic ren_group(bit v0, bit w0, int d0, int a0, int b0,
                             bit v1, bit w1, int d1, int a1, int b1, string tag);
        exp_t e;
        int need, dd[2], aa[2], bb[2];
        bit vv[2], ww[2];
        vv = '{v0, v1}; ww = '{w0, w1};
        dd = '{d0, d1}; aa = '{a0, a1}; bb = '{b0, b1};
        @(negedge clk);
        clear_inputs();
        need = 0;
        for (int i = 0; i < 2; i++) begin
            ren_valid[i] = vv[i]; ren_dst_we[i] = ww[i];
            ren_adst[i] = AW'(dd[i]); ren_asrc1[i] = AW'(aa[i]); ren_asrc2[i] = AW'(bb[i]);
            if (vv[i] && ww[i] && dd[i] != 0) need++;
        end
        e.tag = tag;
        e.ok = (v0 || v1) && !undo_m && (fl_m.size() >= need);
        for (int i = 0; i < 2; i++) begin
            e.v[i] = vv[i];
            e.s1[i] = map_m[aa[i]]; e.s2[i] = map_m[bb[i]]; e.od[i] = map_m[dd[i]];
            e.al[i] = e.ok && vv[i] && ww[i] && dd[i] != 0;
            e.pd[i] = 0;
            if (e.al[i]) begin
                e.pd[i] = fl_m.pop_front();
                map_m[dd[i]] = e.pd[i];
            end
            if (e.ok && vv[i]) recs.push_back('{dd[i], e.pd[i], e.od[i], e.al[i]});
        end
        sbq.push_back(e);
        ->ev_chk;
        @(posedge clk);
    endtask

    task automatic commit_one();
        rec_t r;
        @(negedge clk);
        clear_inputs();
        r = recs.pop_front();
        cm_valid = 1; cm_has_dst = r.has; cm_old_pdst = PW'(r.od);
        if (r.has) fl_m.push_back(r.od);
        @(posedge clk);
    endtask

    // rollback record youngest first, with a rename attempt that must be refused (R9)
    task automatic rollback_step();
        rec_t r;
        exp_t e;
        @(negedge clk);
        clear_inputs();
        r = recs.pop_back();
        rb_active = 1; rb_valid = 1; rb_has_dst = r.has;
        rb_adst = AW'(r.ad); rb_pdst = PW'(r.pd); rb_old_pdst = PW'(r.od);
        ren_valid = 2'b01; ren_dst_we = 2'b01; ren_adst[0] = 5'd3;
        e.tag = "R9 rename during rollback";
        e.ok = 0; e.v = '{0, 0}; e.al = '{0, 0};
        e.pd = '{0, 0}; e.s1 = '{0, 0}; e.s2 = '{0, 0}; e.od = '{0, 0};
        sbq.push_back(e);
        ->ev_chk;
        if (r.has) begin
            map_m[r.ad] = r.od;
            fl_m.push_back(r.pd);
        end
        @(posedge clk);
    endtask

    // monitor: pops the scoreboard and compares once outputs have settled
    initial begin
        exp_t e;
        forever begin
            @(ev_chk);
            #1;
            e = sbq.pop_front();
            check_int({e.tag, " ok"}, int'(ren_ok), int'(e.ok));
            for (int i = 0; i < 2; i++) begin
                if (!e.ok) check_int({e.tag, " R6 no alloc"}, int'(ren_alloc[i]), 0);
                else if (e.v[i]) begin
                    check_int({e.tag, " R2 alloc"}, int'(ren_alloc[i]), int'(e.al[i]));
                    check_int({e.tag, " R5 pdst"}, int'(ren_pdst[i]), e.pd[i]);
                    check_int({e.tag, " R3 src1"}, int'(ren_psrc1[i]), e.s1[i]);
                    check_int({e.tag, " R3 src2"}, int'(ren_psrc2[i]), e.s2[i]);
                    if (e.al[i]) check_int({e.tag, " R4 old"}, int'(ren_old_pdst[i]), e.od[i]);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        clear_inputs();
        ren_ok_dummy = '0;
        for (int i = 0; i < NA; i++) map_m[i] = i;
        for (int i = NA; i < NP; i++) fl_m.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        ren_group(1, 0, 0, 1, 2, 1, 0, 0, 30, 31, "R1 reset map");
        ren_group(1, 1, 5, 5, 7, 1, 1, 3, 5, 0, "R1 R2 R3 first pair");
        ren_group(1, 1, 4, 4, 3, 1, 1, 4, 4, 4, "R4 same dst in group");
        ren_group(1, 0, 0, 4, 3, 0, 0, 0, 0, 0, "R4 younger wins");
        ren_group(1, 1, 0, 4, 0, 1, 1, 9, 0, 4, "R5 zero dst");
        ren_group(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 empty group");

        k = 0;
        while (fl_m.size() >= 2) begin
            ren_group(1, 1, (k % 31) + 1, (k * 7) % 32, (k * 3) % 32,
                      1, 1, ((k + 11) % 31) + 1, (k * 5) % 32, ((k + 11) % 31) + 1, "R2 R3 fill");
            k++;
        end
        ren_group(1, 1, 6, 1, 2, 1, 1, 7, 3, 4, "R6 stall");
        ren_group(1, 0, 0, 6, 7, 0, 0, 0, 0, 0, "R6 unchanged map");
        ren_group(1, 1, 8, 6, 7, 0, 0, 0, 0, 0, "R6 single after stall");

        repeat (5) commit_one();
        ren_group(1, 1, 10, 10, 1, 1, 1, 11, 11, 10, "R7 reuse");
        ren_group(1, 1, 12, 11, 0, 1, 1, 13, 12, 0, "R7 reuse order");

        repeat (6) rollback_step();
        ren_group(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R9 undo exit");
        for (int a = 0; a < 32; a += 4)
            ren_group(1, 0, 0, a, a + 1, 1, 0, 0, a + 2, a + 3, "R8 restored map");

        while (recs.size() > 0) rollback_step();
        ren_group(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R9 undo exit again");
        for (int a = 0; a < 32; a += 4)
            ren_group(1, 0, 0, a, a + 1, 1, 0, 0, a + 2, a + 3, "R8 full restore");
        ren_group(1, 1, 20, 20, 21, 1, 1, 21, 20, 21, "R8 returned reuse");

        @(negedge clk);
        clear_inputs();
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule